// File: doc/BRIEF.md
# Progression Sieve Scanner

The scanner walks a range of sieve positions, one position per clock cycle, starting from position zero. It holds a small bank of arithmetic progressions. Each progression has an interval (normally a prime), a first-hit offset and a weight (roughly the base-2 logarithm of the prime). Every progression keeps its own countdown counter. The counter reaching zero means that the progression divides the current position. In each cycle the weights of all progressions that hit are summed with saturation. When that sum reaches a programmable threshold, the position is reported as a candidate.

Software, or a sequencer, fills the progression slots through a write port while the scanner is idle. It then sets the threshold and the run length and pulses start. The scanner reports each candidate as a valid/index pair and raises a done flag when the run is complete.

Top module: `sieve_scan`

## Requirements
- R1: A write on the configuration port, when the scanner is idle, stores the interval, offset, weight and enable bit in the addressed slot. A write while a run is active is ignored and has no effect on the current run or on later runs.
- R2: A start pulse while idle sets the position to 0, loads every slot counter with that slot's offset and clears done. A start pulse while a run is active is ignored.
- R3: Exactly one position is processed per clock cycle, in increasing order from 0.
- R4: An enabled slot with interval p ≥ 1 and offset o < p hits the positions o, o+p, o+2p and so on. Its counter reloads with p−1 in the same cycle as each hit.
- R5: A slot whose enable bit is 0, including any slot never written since reset, never adds to any sum.
- R6: The per-position sum is the total of the 8-bit unsigned weights of all hitting slots. It is clamped at 2^SUM_W−1 instead of wrapping.
- R7: A position is a candidate when its sum is greater than or equal to the threshold. cand_valid and cand_index appear in the clock cycle after the cycle in which that position was processed.
- R8: After run_len positions, busy falls and done rises in the same cycle, and done stays high until the next start. A run_len of 0 raises done one cycle after start without processing any position.
- R9: After reset, busy, done and cand_valid are 0 and all slots are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_slot | input | $clog2(SLOTS) | Slot address |
| cfg_interval | input | IVL_W | Progression interval p |
| cfg_offset | input | IVL_W | Position of the first hit (less than p) |
| cfg_weight | input | WT_W | Weight added at each hit |
| cfg_enable | input | 1 | Slot enable |
| thresh | input | SUM_W | Candidate threshold, held stable during a run |
| run_len | input | IDX_W | Number of positions to scan |
| start | input | 1 | Start pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete |
| cand_valid | output | 1 | Candidate report valid |
| cand_index | output | IDX_W | Position of the reported candidate |

## Verification
On every cycle, the embedded properties check the following:
- each hitting counter reloads with interval minus one;
- the sum never falls below any single hitting weight, so it cannot wrap;
- candidate reports come only out of active cycles, with consecutive indices;
- busy and done are never high together.

Only the bench's scenarios can show the rest:
- which positions become candidates (offsets, mixed intervals, thresholds of zero and maximum);
- the exact reporting latency;
- the run length, including a length of zero;
- that configuration writes and start pulses during a run are ignored.

// File: rtl/sieve_scan.sv
module sieve_scan #(
  parameter int SLOTS = 16,
  parameter int IVL_W = 16,
  parameter int WT_W  = 8,
  parameter int SUM_W = 10,
  parameter int IDX_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(SLOTS)-1:0] cfg_slot,
  input  logic [IVL_W-1:0]         cfg_interval,
  input  logic [IVL_W-1:0]         cfg_offset,
  input  logic [WT_W-1:0]          cfg_weight,
  input  logic                     cfg_enable,
  input  logic [SUM_W-1:0]         thresh,
  input  logic [IDX_W-1:0]         run_len,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     cand_valid,
  output logic [IDX_W-1:0]         cand_index
);
  localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

  logic [IVL_W-1:0] ivl [SLOTS];
  logic [IVL_W-1:0] ofs [SLOTS];
  logic [IVL_W-1:0] cnt [SLOTS];
  logic [WT_W-1:0]  wt  [SLOTS];
  logic [SLOTS-1:0] en;
  logic [SLOTS-1:0] hit;
  logic [IDX_W-1:0] idx;
  logic [SUM_W-1:0] sum;

  wire go   = start && !busy;
  wire last = busy && (idx == run_len - IDX_W'(1));

  always_comb begin
    logic [SUM_W:0] t;
    sum = '0;
    for (int i = 0; i < SLOTS; i++) begin
      t   = {1'b0, sum} + (hit[i] ? (SUM_W+1)'(wt[i]) : '0);
      sum = t[SUM_W] ? '1 : t[SUM_W-1:0];
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign hit[g] = en[g] && (cnt[g] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ivl[g] <= '0;
        ofs[g] <= '0;
        wt[g]  <= '0;
        en[g]  <= 1'b0;
        cnt[g] <= '0;
      end else begin
        if (cfg_we && !busy && (int'(cfg_slot) == g)) begin
          ivl[g] <= cfg_interval;
          ofs[g] <= cfg_offset;
          wt[g]  <= cfg_weight;
          en[g]  <= cfg_enable;
        end
        if (go)
          cnt[g] <= ofs[g];
        else if (busy)
          cnt[g] <= hit[g] ? ivl[g] - ONE : cnt[g] - ONE;
      end
    end

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && hit[g] |=> cnt[g] == $past(ivl[g]) - ONE); // R4
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |-> sum >= SUM_W'(wt[g])); // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      idx        <= '0;
      cand_valid <= 1'b0;
      cand_index <= '0;
    end else begin
      cand_valid <= busy && (sum >= thresh);
      cand_index <= idx;
      if (go) begin
        idx  <= '0;
        busy <= (run_len != '0);
        done <= (run_len == '0);
      end else if (busy) begin
        idx <= idx + IDX_W'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R8
  AST_CAND_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> $past(busy)); // R7
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && $past(cand_valid) |-> cand_index == $past(cand_index) + IDX_W'(1)); // R3
  AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start) || $past(busy)); // R8
endmodule

// File: tb/sim_sieve_scan.sv
module sim_sieve_scan;
  localparam int SLOTS = 16, IVL_W = 16, WT_W = 8, SUM_W = 10, IDX_W = 20;
  localparam int SMAX = (1 << SUM_W) - 1;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_enable = 0, start = 0;
  logic [$clog2(SLOTS)-1:0] cfg_slot = '0;
  logic [IVL_W-1:0] cfg_interval = '0, cfg_offset = '0;
  logic [WT_W-1:0] cfg_weight = '0;
  logic [SUM_W-1:0] thresh = '0;
  logic [IDX_W-1:0] run_len = '0;
  logic busy, done, cand_valid;
  logic [IDX_W-1:0] cand_index;

  always #2 clk = ~clk;

  sieve_scan #(.SLOTS(SLOTS), .IVL_W(IVL_W), .WT_W(WT_W), .SUM_W(SUM_W), .IDX_W(IDX_W)) u0 (
    .clk, .rst_n, .cfg_we, .cfg_slot, .cfg_interval, .cfg_offset, .cfg_weight,
    .cfg_enable, .thresh, .run_len, .start, .busy, .done, .cand_valid, .cand_index);

  int n_chk = 0, n_bad = 0;
  int m_ivl [SLOTS], m_ofs [SLOTS], m_wt [SLOTS];
  bit m_en [SLOTS];
  bit got [512];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_sum(int a);
    int s = 0;
    for (int i = 0; i < SLOTS; i++)
      if (m_en[i] && a >= m_ofs[i] && ((a - m_ofs[i]) % m_ivl[i]) == 0) s += m_wt[i];
    return (s > SMAX) ? SMAX : s;
  endfunction

  task automatic cfg(int s, int p, int o, int w, bit e);
    cfg_slot = s[$clog2(SLOTS)-1:0]; cfg_interval = p[IVL_W-1:0];
    cfg_offset = o[IVL_W-1:0]; cfg_weight = w[WT_W-1:0]; cfg_enable = e;
    cfg_we = 1; @(negedge clk); cfg_we = 0;
    m_ivl[s] = p; m_ofs[s] = o; m_wt[s] = w; m_en[s] = e;
  endtask

  task automatic clear_all();
    for (int i = 0; i < SLOTS; i++) cfg(i, 1, 0, 0, 0);
  endtask

  task automatic run_case(int len, int thr, bit poke, string tag);
    int n;
    bit fin = 0;
    foreach (got[i]) got[i] = 0;
    thresh = thr[SUM_W-1:0]; run_len = len[IDX_W-1:0];
    start = 1; @(negedge clk); start = 0; n = 1;
    while (!fin && n < len + 20) begin
      if (poke && n == 5) begin cfg_slot = '0; cfg_interval = 1; cfg_offset = 0;
        cfg_weight = 8'd200; cfg_enable = 1; cfg_we = 1; end
      if (poke && n == 6) cfg_we = 0;
      if (poke && n == 7) start = 1;
      if (poke && n == 8) start = 0;
      if (cand_valid) begin
        chk(int'(cand_index) == n - 2, {"R7 latency ", tag}, int'(cand_index), n - 2);
        if (cand_index < 512) got[cand_index] = 1;
      end
      if (done) begin
        chk(n == len + 1, {"R8 run length ", tag}, n, len + 1);
        chk(!busy, {"R8 busy low ", tag}, busy, 0);
        fin = 1;
      end else begin
        @(negedge clk); n++;
      end
    end
    if (!fin) chk(0, {"R8 done missing ", tag}, 0, 1);
    for (int a = 0; a < len; a++)
      chk(got[a] == (exp_sum(a) >= thr), {"R4/R6 candidate ", tag}, got[a], exp_sum(a) >= thr);
    @(negedge clk);
    chk(done, {"R8 done held ", tag}, done, 1);
  endtask

  initial begin
    #(4 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd97531));
    for (int i = 0; i < SLOTS; i++) begin m_ivl[i] = 1; m_ofs[i] = 0; m_wt[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cand_valid, "R9 reset outputs", {busy, done, cand_valid}, 0);
    rst_n = 1; @(negedge clk);
    chk(!busy && !done && !cand_valid, "R9 after release", {busy, done, cand_valid}, 0);
    run_case(20, 1, 0, "R9/R5 unwritten slots");

    clear_all();
    cfg(0, 2, 0, 1, 1); cfg(1, 3, 1, 2, 1); cfg(2, 5, 3, 2, 1); cfg(3, 7, 0, 3, 1);
    run_case(100, 4, 0, "R4 small primes");
    chk(!busy, "R3 idle after run", busy, 0);

    clear_all(); cfg(4, 1, 0, 9, 1);
    run_case(30, 9, 0, "R4 interval one");

    cfg(5, 1, 0, 250, 0); cfg(6, 3, 0, 5, 1);
    run_case(40, 10, 0, "R5 disabled slot");

    for (int i = 0; i < SLOTS; i++) cfg(i, 1, 0, 255, 1);
    run_case(25, SMAX, 0, "R6 saturation");

    clear_all(); cfg(2, 4, 2, 3, 1);
    run_case(30, 0, 0, "R7 zero threshold");
    run_case(0, 0, 0, "R8 zero length");

    cfg(0, 6, 1, 7, 1); cfg(1, 4, 3, 7, 1);
    run_case(60, 7, 1, "R1/R2 writes and start during run");
    run_case(60, 7, 0, "R1 config kept");

    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < SLOTS; i++) begin
        int p = 1 + int'($urandom_range(39));
        cfg(i, p, int'($urandom_range(p - 1)), int'($urandom_range(255)), bit'($urandom_range(1)));
      end
      run_case(50 + int'($urandom_range(250)), int'($urandom_range(600)), 0, "R6/R7 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule